// File: doc/BRIEF.md
# Per-Bank DRAM Command Timing Guard

This block watches a stream of already-decoded commands for a four-bank double-data-rate DRAM. The commands are activate, read, write, precharge, precharge-all, auto-refresh and mode set. Each command carries a bank number and an auto-precharge flag. For each bank the guard keeps an open or closed bit and a set of down-counters. It also keeps three counters shared by all banks: activate-to-activate spacing, mode-set recovery, and write-to-read turnaround. For every command it reports a combinational verdict in the same cycle. The verdict is either legal or a numbered violation code. A controller can use the verdict to gate command issue, or the block can sit passively as a protocol monitor.

The command input is a one-way stream. `cmd_valid` marks a command, and there is no ready signal, because the guard accepts a command in every cycle and never applies back-pressure. The verdict is meaningful in the cycle the command is presented. The guard samples the command and updates its state at the next rising clock edge. It does this whether or not the command was legal, so that its view of the DRAM follows what was actually issued.

All spacings are parameters counted in clocks. The defaults describe a 400 MHz grade at CAS latency 5 with a burst of 4. Two spacings are derived from the others. The activate-to-write spacing is the activate-to-read spacing minus 2, with a floor of 2. The write recovery before an automatic precharge is CAS latency plus 1.

Top module: `bank_timing_guard`

## Requirements
- R1: Opcode encoding on `cmd_op` is 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all, 6 auto-refresh, 7 mode set. With `cmd_valid` low, or with a no-op, `verdict_ok` is 1 and `verdict_code` is 0. Every other legal command also gives code 0. Any nonzero code drives `verdict_ok` low.
- R2: A read or write to a closed bank gives code 1. An activate to a bank that is already open gives code 2.
- R3: An auto-refresh or a mode set issued while any bank is open gives code 3.
- R4: A read needs at least T_RCDRD clocks after that bank's activate. A write needs at least max(T_RCDRD-2, 2) clocks. A command issued earlier gives code 4.
- R5: A precharge of an open bank, single or all-bank, issued fewer than T_RAS clocks after its activate gives code 5. A precharge of a closed bank is legal and has no effect.
- R6: An activate gives code 6 if it is too early for its bank, or an auto-refresh gives code 6 if any bank is still recovering. A bank recovers T_RC clocks after its activate, T_RP after a precharge, BL/2+T_RP after a read with auto-precharge, BL/2+CL+1+T_RP after a write with auto-precharge, and T_RFC after an auto-refresh.
- R7: Two activates to any banks need at least T_RRD clocks between them, else code 7.
- R8: After a mode set, any command other than a no-op within T_MRD clocks gives code 8.
- R9: A read needs at least BL/2+2 clocks after the last write, else code 9. Column commands that meet every other rule may follow each other in consecutive cycles.
- R10: A flagged command still updates state. A precharge or precharge-all closes its banks, an activate reopens its bank and restarts that bank's timers, and a refresh or mode set restarts its timers.
- R11: A read or write with the auto-precharge flag set closes its bank, so a following read to that bank gives code 1.
- R12: When several rules fail, code 8 wins over the others. Next come the state codes (1, 2, 3), and then the timing codes in the order 6, 7 for activate and 4, 9 for read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset; clears all banks to closed and all timers to expired |
| cmd_valid | input | 1 | A command is present this cycle; there is no back-pressure |
| cmd_op | input | 3 | Command opcode (encoding in R1) |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Auto-precharge flag for read and write |
| verdict_ok | output | 1 | Command legal (combinational) |
| verdict_code | output | 4 | Violation code, 0 when legal |

## Verification
The bench places commands exactly one clock before and exactly at each spacing limit. A counter loaded with N instead of N-1 would flag the boundary command, and one loaded with N-2 would pass the early one. It issues violating precharges and activates and then probes the bank state. A design that skipped the state update on a violation would report code 0 instead of 1 or 6 on the probe. Read and write with auto-precharge are followed by a read and by an early activate. These catch a missing close and a recovery that ignores CAS latency or burst length. Paired rule failures check the priority order, because a wrong order would report the lower-ranked code.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_PREA = 3'd5,
    OP_REF  = 3'd6,
    OP_MRS  = 3'd7
  } cmd_op_e;

  typedef enum logic [3:0] {
    V_OK     = 4'd0,
    V_CLOSED = 4'd1,
    V_OPEN   = 4'd2,
    V_BUSY   = 4'd3,
    V_RCD    = 4'd4,
    V_RAS    = 4'd5,
    V_ACT    = 4'd6,
    V_RRD    = 4'd7,
    V_MRD    = 4'd8,
    V_WTR    = 4'd9
  } verdict_e;

endpackage

// File: rtl/gap_timer.sv
// Saturating down-counter: idle once N clocks have passed since the last load.
module gap_timer #(
  parameter int CW = 6,
  parameter int N  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic idle
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= CW'(N - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign idle = (cnt_q == '0);
endmodule

// File: rtl/bank_slot.sv
// One bank: open bit plus the timers that gate column, precharge and activate.
module bank_slot #(
  parameter int CW      = 6,
  parameter int N_RCDRD = 6,
  parameter int N_RCDWR = 4,
  parameter int N_RAS   = 12,
  parameter int N_RC    = 18,
  parameter int N_RP    = 6,
  parameter int N_RDAP  = 8,
  parameter int N_WRAP  = 14,
  parameter int N_RFC   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_act,
  input  logic do_rd,
  input  logic do_wr,
  input  logic do_pre,
  input  logic do_ref,
  input  logic ap,
  output logic open_o,
  output logic rd_ok,
  output logic wr_ok,
  output logic pre_ok,
  output logic act_ok
);
  logic          open_q, open_d;
  logic [CW-1:0] rd_q, wr_q, ras_q, gap_q;
  logic [CW-1:0] rd_d, wr_d, ras_d, gap_d;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  function automatic logic [CW-1:0] atleast(input logic [CW-1:0] v, input int n);
    logic [CW-1:0] f;
    f = CW'(n - 1);
    return (v > f) ? v : f;
  endfunction

  always_comb begin
    open_d = open_q;
    rd_d   = dec(rd_q);
    wr_d   = dec(wr_q);
    ras_d  = dec(ras_q);
    gap_d  = dec(gap_q);
    if (do_act) begin
      open_d = 1'b1;
      rd_d   = CW'(N_RCDRD - 1);
      wr_d   = CW'(N_RCDWR - 1);
      ras_d  = CW'(N_RAS - 1);
      gap_d  = CW'(N_RC - 1);
    end else if (do_pre) begin
      if (open_q) begin
        open_d = 1'b0;
        gap_d  = atleast(dec(gap_q), N_RP);
      end
    end else if ((do_rd || do_wr) && ap && open_q) begin
      open_d = 1'b0;
      gap_d  = atleast(dec(gap_q), do_wr ? N_WRAP : N_RDAP);
    end else if (do_ref) begin
      gap_d  = atleast(dec(gap_q), N_RFC);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rd_q   <= '0;
      wr_q   <= '0;
      ras_q  <= '0;
      gap_q  <= '0;
    end else begin
      open_q <= open_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      ras_q  <= ras_d;
      gap_q  <= gap_d;
    end
  end

  assign open_o = open_q;
  assign rd_ok  = (rd_q == '0);
  assign wr_ok  = (wr_q == '0);
  assign pre_ok = !open_q || (ras_q == '0);
  assign act_ok = (gap_q == '0);
endmodule

// File: rtl/bank_timing_guard.sv
module bank_timing_guard
  import bank_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RC      = 18,
  parameter int T_RFC     = 20,
  parameter int T_RAS     = 12,
  parameter int T_RCDRD   = 6,
  parameter int T_RP      = 6,
  parameter int T_RRD     = 4,
  parameter int T_MRD     = 4,
  parameter int CAS_LAT   = 5,
  parameter int BURST_LEN = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [BA_W-1:0] cmd_bank,
  input  logic            cmd_ap,
  output logic            verdict_ok,
  output logic [3:0]      verdict_code
);
  localparam int T_RCDWR = (T_RCDRD - 2 < 2) ? 2 : T_RCDRD - 2;
  localparam int BEATS   = BURST_LEN / 2;
  localparam int T_WREC  = CAS_LAT + 1;
  localparam int T_WTR   = BEATS + 2;
  localparam int N_RDAP  = BEATS + T_RP;
  localparam int N_WRAP  = BEATS + T_WREC + T_RP;
  localparam int CW      = $clog2(T_RC + T_RFC + N_WRAP + T_MRD + T_WTR + 2);

  cmd_op_e  op;
  logic     live;
  verdict_e code;

  logic [NUM_BANKS-1:0] sel, b_open, b_rd_ok, b_wr_ok, b_pre_ok, b_act_ok;
  logic rrd_idle, mrd_idle, wtr_idle;

  assign op   = cmd_op_e'(cmd_op);
  assign live = cmd_valid && (op != OP_NOP);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign sel[g] = (cmd_bank == BA_W'(g));
    bank_slot #(
      .CW(CW), .N_RCDRD(T_RCDRD), .N_RCDWR(T_RCDWR), .N_RAS(T_RAS),
      .N_RC(T_RC), .N_RP(T_RP), .N_RDAP(N_RDAP), .N_WRAP(N_WRAP), .N_RFC(T_RFC)
    ) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .do_act (live && op == OP_ACT && sel[g]),
      .do_rd  (live && op == OP_RD  && sel[g]),
      .do_wr  (live && op == OP_WR  && sel[g]),
      .do_pre (live && ((op == OP_PRE && sel[g]) || op == OP_PREA)),
      .do_ref (live && op == OP_REF),
      .ap     (cmd_ap),
      .open_o (b_open[g]),
      .rd_ok  (b_rd_ok[g]),
      .wr_ok  (b_wr_ok[g]),
      .pre_ok (b_pre_ok[g]),
      .act_ok (b_act_ok[g])
    );
  end

  gap_timer #(.CW(CW), .N(T_RRD)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(live && op == OP_ACT), .idle(rrd_idle));
  gap_timer #(.CW(CW), .N(T_MRD)) u_mrd (
    .clk(clk), .rst_n(rst_n), .load(live && op == OP_MRS), .idle(mrd_idle));
  gap_timer #(.CW(CW), .N(T_WTR)) u_wtr (
    .clk(clk), .rst_n(rst_n), .load(live && op == OP_WR), .idle(wtr_idle));

  always_comb begin
    code = V_OK;
    if (live) begin
      if (!mrd_idle) begin
        code = V_MRD;
      end else begin
        unique case (op)
          OP_ACT: begin
            if (b_open[cmd_bank])        code = V_OPEN;
            else if (!b_act_ok[cmd_bank]) code = V_ACT;
            else if (!rrd_idle)           code = V_RRD;
          end
          OP_RD: begin
            if (!b_open[cmd_bank])       code = V_CLOSED;
            else if (!b_rd_ok[cmd_bank]) code = V_RCD;
            else if (!wtr_idle)          code = V_WTR;
          end
          OP_WR: begin
            if (!b_open[cmd_bank])       code = V_CLOSED;
            else if (!b_wr_ok[cmd_bank]) code = V_RCD;
          end
          OP_PRE:  if (!b_pre_ok[cmd_bank]) code = V_RAS;
          OP_PREA: if (!(&b_pre_ok))        code = V_RAS;
          OP_REF: begin
            if (|b_open)                 code = V_BUSY;
            else if (!(&b_act_ok))       code = V_ACT;
          end
          OP_MRS:  if (|b_open)             code = V_BUSY;
          default: code = V_OK;
        endcase
      end
    end
  end

  assign verdict_code = code;
  assign verdict_ok   = (code == V_OK);
endmodule

// File: rtl/bank_timing_guard_chk.sv
module bank_timing_guard_chk
  import bank_guard_pkg::*;
#(
  parameter int T_RCDRD = 6,
  parameter int T_RRD   = 4,
  parameter int T_MRD   = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic [1:0] cmd_bank,
  input logic       verdict_ok,
  input logic [3:0] verdict_code
);
  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (verdict_ok && verdict_code == 4'd0))
    else $error("idle cycle gave a violation");

  if (T_RCDRD > 1) begin : g_rcd
    assert_rcd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_ACT) |=>
      !(cmd_valid && cmd_op == OP_RD && cmd_bank == $past(cmd_bank) && verdict_ok))
      else $error("read right after activate passed");
  end

  if (T_RRD > 1) begin : g_rrd
    assert_rrd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_ACT) |=> !(cmd_valid && cmd_op == OP_ACT && verdict_ok))
      else $error("back-to-back activates passed");
  end

  if (T_MRD > 1) begin : g_mrd
    assert_mrd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_MRS) |=>
      !(cmd_valid && cmd_op != OP_NOP && verdict_ok))
      else $error("command right after mode set passed");
  end

  assert_wtr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WR) |=> !(cmd_valid && cmd_op == OP_RD && verdict_ok))
    else $error("read right after write passed");

  assert_closeall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PREA) |=>
    !(cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR) && verdict_ok))
    else $error("column command after precharge-all passed");
endmodule

bind bank_timing_guard bank_timing_guard_chk #(
  .T_RCDRD(T_RCDRD), .T_RRD(T_RRD), .T_MRD(T_MRD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .verdict_ok(verdict_ok), .verdict_code(verdict_code)
);

// File: tb/tb_bank_timing_guard.sv
module tb_bank_timing_guard;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, PREA = 3'd5, REF = 3'd6, MRS = 3'd7;
  localparam logic [3:0] OK = 4'd0, CLOSED = 4'd1, OPENB = 4'd2, BUSY = 4'd3,
                         RCD = 4'd4, RAS = 4'd5, ACTG = 4'd6, RRD = 4'd7,
                         MRDG = 4'd8, WTR = 4'd9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ap = 1'b0;
  logic [2:0] cmd_op = NOP;
  logic [1:0] cmd_bank = 2'd0;
  logic verdict_ok;
  logic [3:0] verdict_code;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bank_timing_guard dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
    .verdict_ok(verdict_ok), .verdict_code(verdict_code)
  );

  task automatic check(input logic [3:0] exp, input string tag);
    n_chk++;
    if (verdict_code !== exp || verdict_ok !== (exp == OK)) begin
      n_fail++;
      $display("FAIL %s: code=%0d ok=%0b expected code=%0d ok=%0b",
               tag, verdict_code, verdict_ok, exp, exp == OK);
    end
  endtask

  task automatic put(input logic [2:0] op, input logic [1:0] bank, input logic ap,
                     input logic [3:0] exp, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank; cmd_ap = ap;
    #1 check(exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = NOP; cmd_ap = 1'b0;
    end
  endtask

  task automatic t_reset;
    @(negedge clk); #1 check(OK, "R1 reset idle verdict");
    put(NOP, 2'd1, 1'b0, OK, "R1 no-op");
    put(REF, 2'd0, 1'b0, OK, "R3 refresh with all banks idle");
    idle(30);
  endtask

  task automatic t_state;
    put(RD,  2'd0, 1'b0, CLOSED, "R2 read closed bank");
    put(ACT, 2'd0, 1'b0, OK,     "R2 activate idle bank");
    idle(30);
    put(ACT, 2'd0, 1'b0, OPENB,  "R2 activate open bank");
    idle(30);
    put(WR,  2'd1, 1'b0, CLOSED, "R2 write closed bank");
    put(PRE, 2'd0, 1'b0, OK,     "R5 precharge after tRAS");
    put(PRE, 2'd2, 1'b0, OK,     "R5 precharge closed bank");
    idle(30);
  endtask

  task automatic t_rcd;
    put(ACT, 2'd1, 1'b0, OK,  "R4 activate");
    idle(2);
    put(WR,  2'd1, 1'b0, RCD, "R4 write one clock early");
    put(WR,  2'd1, 1'b0, OK,  "R4 write at limit");
    put(RD,  2'd1, 1'b0, RCD, "R12 read early, rcd ranks over wtr");
    put(RD,  2'd1, 1'b0, WTR, "R9 read too soon after write");
    idle(1);
    put(RD,  2'd1, 1'b0, OK,  "R9 read at write-to-read limit");
    put(RD,  2'd1, 1'b0, OK,  "R9 back-to-back read");
    put(PRE, 2'd1, 1'b0, RAS, "R5 precharge before tRAS");
    put(RD,  2'd1, 1'b0, CLOSED, "R10 flagged precharge closed bank");
    put(ACT, 2'd1, 1'b0, ACTG, "R6 activate inside tRC");
    idle(30);
    put(PRE, 2'd1, 1'b0, OK,  "R10 flagged activate reopened bank");
    idle(30);
  endtask

  task automatic t_rp;
    put(ACT, 2'd2, 1'b0, OK, "R6 activate");
    idle(30);
    put(PRE, 2'd2, 1'b0, OK, "R6 precharge");
    idle(4);
    put(ACT, 2'd2, 1'b0, ACTG, "R6 activate one clock inside tRP");
    idle(30);
    put(PRE, 2'd2, 1'b0, OK, "R6 precharge");
    idle(5);
    put(ACT, 2'd2, 1'b0, OK, "R6 activate at tRP");
    idle(30);
    put(PRE, 2'd2, 1'b0, OK, "R6 close");
    idle(30);
  endtask

  task automatic t_rc;
    put(ACT, 2'd3, 1'b0, OK, "R11 activate");
    idle(5);
    put(RD,  2'd3, 1'b1, OK, "R11 read with auto-precharge");
    put(RD,  2'd3, 1'b0, CLOSED, "R11 bank closed by auto-precharge");
    idle(9);
    put(ACT, 2'd3, 1'b0, ACTG, "R6 activate one clock inside tRC");
    idle(30);
    put(PRE, 2'd3, 1'b0, OK, "R6 close");
    idle(30);
  endtask

  task automatic t_wrap;
    put(ACT, 2'd0, 1'b0, OK, "R6 activate");
    idle(20);
    put(WR,  2'd0, 1'b1, OK, "R6 write with auto-precharge");
    idle(12);
    put(ACT, 2'd0, 1'b0, ACTG, "R6 activate one clock before write recovery");
    idle(30);
    put(PRE, 2'd0, 1'b0, OK, "R6 close");
    idle(30);
    put(ACT, 2'd0, 1'b0, OK, "R6 activate");
    idle(20);
    put(WR,  2'd0, 1'b1, OK, "R6 write with auto-precharge");
    idle(13);
    put(ACT, 2'd0, 1'b0, OK, "R6 activate at write recovery limit");
    idle(30);
    put(PRE, 2'd0, 1'b0, OK, "R6 close");
    idle(30);
  endtask

  task automatic t_rrd;
    put(ACT, 2'd1, 1'b0, OK,  "R7 first activate");
    idle(1);
    put(ACT, 2'd2, 1'b0, RRD, "R7 second bank too soon");
    idle(2);
    put(ACT, 2'd3, 1'b0, RRD, "R7 flagged activate restarts spacing");
    idle(3);
    put(ACT, 2'd0, 1'b0, OK,  "R7 activate at tRRD");
    put(PREA, 2'd0, 1'b0, RAS, "R5 precharge-all with young bank");
    put(RD,  2'd1, 1'b0, CLOSED, "R10 precharge-all closed every bank");
    idle(30);
  endtask

  task automatic t_ref;
    put(ACT, 2'd0, 1'b0, OK,   "R3 activate");
    put(REF, 2'd0, 1'b0, BUSY, "R3 refresh with open bank");
    idle(15);
    put(PRE, 2'd0, 1'b0, OK,   "R3 close");
    idle(30);
    put(REF, 2'd0, 1'b0, OK,   "R6 refresh");
    idle(18);
    put(ACT, 2'd1, 1'b0, ACTG, "R6 activate one clock inside tRFC");
    idle(30);
    put(PRE, 2'd1, 1'b0, OK,   "R6 close");
    idle(30);
  endtask

  task automatic t_mrs;
    put(ACT, 2'd2, 1'b0, OK,   "R3 activate");
    put(MRS, 2'd0, 1'b0, BUSY, "R3 mode set with open bank");
    idle(15);
    put(PRE, 2'd2, 1'b0, OK,   "R3 close");
    idle(30);
    put(MRS, 2'd0, 1'b0, OK,   "R8 mode set idle");
    put(PRE, 2'd2, 1'b0, MRDG, "R8 command right after mode set");
    idle(1);
    put(PRE, 2'd2, 1'b0, MRDG, "R8 command one clock inside tMRD");
    put(PRE, 2'd2, 1'b0, OK,   "R8 command at tMRD");
    idle(30);
    put(MRS, 2'd0, 1'b0, OK,   "R8 mode set idle");
    put(RD,  2'd0, 1'b0, MRDG, "R12 mode-set recovery ranks over closed bank");
    idle(30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_state();
    t_rcd();
    t_rp();
    t_rc();
    t_wrap();
    t_rrd();
    t_ref();
    t_mrs();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: run state=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule